// File: doc/BRIEF.md
# Tile Supply and Clock Controller

This block sets the operating point of one processing tile: which supply rail feeds the core (high, low, or none) and how fast the local oscillator runs. The rails are reached through two banks of parallel power-gate segments, and the oscillator is modelled by a run enable, a divider setting and a divided tick output. The analog gates and the ring oscillator sit outside; this block only drives their enables.

The wanted operating point comes from one of three places: fixed configuration pins, a register written by software, or a hardware policy. The policy counts core stall cycles over fixed 256-cycle windows and also looks at how full the tile's input FIFO is. It asks for the high rail with the fastest clock when the tile is overloaded and for the low rail with a slow clock when it is lightly loaded. A rail change is made safely: the clock stops, the old bank is turned off one segment per cycle, the new bank is turned on one segment per cycle, a short settle delay passes, and only then does the clock restart. Separately, a core that sits idle with an empty FIFO for a whole window has its clock stopped until data arrives.

Top module: `tile_dvfs_ctrl`

## Requirements
- R1: After reset all 48 high-rail segments are on, all low-rail segments are off, `busy` is 0, `osc_div` is 0 and `osc_run` is 1.
- R2: `src_sel` picks the requested point: 0 takes `cfg_rail`/`cfg_div`, 1 takes the software register loaded from `sw_rail`/`sw_div` on a cycle with `sw_we` high, 2 or 3 takes the hardware policy; a software write has no effect while another source is selected.
- R3: Rail codes are 0 = disconnected, 1 = low, 2 = high, 3 = disconnected; no low-rail segment is ever on in a cycle where a high-rail segment is on.
- R4: A rail change runs halt (1 cycle), old-bank turn-off one segment per cycle (48 cycles, skipped when leaving disconnected), new-bank turn-on one segment per cycle (48 cycles, skipped when going to disconnected), settle (4 cycles); `busy` is high for exactly 101 cycles low↔high and 53 cycles to or from disconnected, and at its end the target bank is fully on and the other fully off.
- R5: `osc_run` is 0 on every cycle in which any segment enable changes, throughout `busy`, and while the rail is disconnected; `clk_tick` never pulses while `osc_run` is 0.
- R6: A new request arriving during a transition does not alter it; the running transition ends at its original target and the new request is served afterwards.
- R7: While running, `clk_tick` pulses once every `osc_div`+1 cycles; a divider change without a rail change is applied on the next cycle without raising `busy`.
- R8: At the close of each 256-cycle window the hardware policy picks high rail with divider 0 if the stall count exceeds 128 or `fifo_level` is at least 56, else low rail with divider 3 if the stall count is below 32, else keeps its previous choice.
- R9: When `core_idle` is high and `fifo_level` is 0 for 256 consecutive cycles, `osc_run` goes low; it returns high in the same cycle that `fifo_level` becomes non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on control clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_sel | input | 2 | Operating-point source select |
| cfg_rail | input | 2 | Static rail request |
| cfg_div | input | 4 | Static divider request |
| sw_we | input | 1 | Software register write strobe |
| sw_rail | input | 2 | Software rail value |
| sw_div | input | 4 | Software divider value |
| fifo_level | input | 7 | Input FIFO occupancy |
| core_stall | input | 1 | Core stalled this cycle |
| core_idle | input | 1 | Core has no work this cycle |
| hi_seg_en | output | 48 | High-rail gate segment enables |
| lo_seg_en | output | 48 | Low-rail gate segment enables |
| osc_run | output | 1 | Oscillator run enable |
| clk_tick | output | 1 | Divided clock pulse |
| osc_div | output | 4 | Divider setting in use |
| busy | output | 1 | Rail transition in progress |

## Verification
The hazard of interest is a request change landing while a rail transition is in flight: the controller is then both sequencing segments and seeing a fresh operating point. The bench starts a low-to-high change from the static pins and, twenty cycles in, changes the pins to request disconnection. A scoreboard queue holds the expected rail and busy length of each transition; the monitor pops an entry on every falling edge of `busy` and requires the first completion to show the high bank full with a 101-cycle duration and the second to show both banks empty after 53 cycles, while per-cycle checks confirm the banks never overlap and the clock stays stopped as segments move.

// File: rtl/tile_dvfs_ctrl.sv
module tile_dvfs_ctrl #(
  parameter int SEGS     = 48,
  parameter int DIV_W    = 4,
  parameter int LVL_W    = 7,
  parameter int WIN      = 256,
  parameter int SETTLE   = 4,
  parameter int HI_TH    = 128,
  parameter int LO_TH    = 32,
  parameter int FULL_TH  = 56,
  parameter int SLOW_DIV = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       src_sel,
  input  logic [1:0]       cfg_rail,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             sw_we,
  input  logic [1:0]       sw_rail,
  input  logic [DIV_W-1:0] sw_div,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             core_stall,
  input  logic             core_idle,
  output logic [SEGS-1:0]  hi_seg_en,
  output logic [SEGS-1:0]  lo_seg_en,
  output logic             osc_run,
  output logic             clk_tick,
  output logic [DIV_W-1:0] osc_div,
  output logic             busy
);
  localparam int WIN_W = $clog2(WIN);
  localparam int SEG_W = $clog2(SEGS);
  localparam int SET_W = $clog2(SETTLE + 1);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN - 1);
  localparam logic [SEG_W-1:0] SEG_LAST = SEG_W'(SEGS - 1);
  localparam logic [SET_W-1:0] SET_LAST = SET_W'(SETTLE - 1);
  localparam logic [WIN_W:0]   HI_V     = (WIN_W+1)'(HI_TH);
  localparam logic [WIN_W:0]   LO_V     = (WIN_W+1)'(LO_TH);
  localparam logic [LVL_W-1:0] FULL_V   = LVL_W'(FULL_TH);
  localparam logic [DIV_W-1:0] SLOW_V   = DIV_W'(SLOW_DIV);
  localparam logic [1:0] R_OFF = 2'd0, R_LOW = 2'd1, R_HIGH = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_HALT, S_DROP, S_ADD, S_SETTLE} state_t;

  function automatic logic [1:0] norm(input logic [1:0] r);
    return (r == 2'd3) ? R_OFF : r;
  endfunction

  state_t           state;
  logic [1:0]       cur_rail, tgt_rail, req_rail, sw_rail_q, hw_rail;
  logic [DIV_W-1:0] tgt_div, req_div, sw_div_q, hw_div, div_cnt;
  logic [SEG_W-1:0] seg_i;
  logic [SET_W-1:0] set_cnt;
  logic [WIN_W-1:0] win_cnt, idle_cnt;
  logic [WIN_W:0]   stall_cnt, stall_tot;
  logic             idle_halt, fifo_empty, win_end;

  assign fifo_empty = (fifo_level == '0);
  assign win_end    = (win_cnt == WIN_LAST);
  assign stall_tot  = stall_cnt + {{WIN_W{1'b0}}, core_stall};
  assign busy       = (state != S_IDLE);
  assign osc_run    = !busy && cur_rail != R_OFF && !(idle_halt && fifo_empty);
  assign clk_tick   = osc_run && (div_cnt >= osc_div);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sw_rail_q <= R_HIGH;
      sw_div_q  <= '0;
    end else if (sw_we) begin
      sw_rail_q <= norm(sw_rail);
      sw_div_q  <= sw_div;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_cnt   <= '0;
      stall_cnt <= '0;
      hw_rail   <= R_HIGH;
      hw_div    <= '0;
    end else begin
      win_cnt <= win_end ? '0 : win_cnt + 1'b1;
      if (win_end) begin
        stall_cnt <= '0;
        if (stall_tot > HI_V || fifo_level >= FULL_V) begin
          hw_rail <= R_HIGH;
          hw_div  <= '0;
        end else if (stall_tot < LO_V) begin
          hw_rail <= R_LOW;
          hw_div  <= SLOW_V;
        end
      end else begin
        stall_cnt <= stall_tot;
      end
    end
  end

  always_comb begin
    case (src_sel)
      2'd0:    begin req_rail = norm(cfg_rail); req_div = cfg_div;  end
      2'd1:    begin req_rail = sw_rail_q;      req_div = sw_div_q; end
      default: begin req_rail = hw_rail;        req_div = hw_div;   end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cur_rail  <= R_HIGH;
      tgt_rail  <= R_HIGH;
      tgt_div   <= '0;
      seg_i     <= '0;
      set_cnt   <= '0;
      hi_seg_en <= '1;
      lo_seg_en <= '0;
      osc_div   <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (req_rail != cur_rail) begin
            state    <= S_HALT;
            tgt_rail <= req_rail;
            tgt_div  <= req_div;
          end else if (cur_rail != R_OFF) begin
            osc_div <= req_div;
          end
        end
        S_HALT: begin
          seg_i   <= '0;
          set_cnt <= '0;
          state   <= (cur_rail == R_OFF) ? S_ADD : S_DROP;
        end
        S_DROP: begin
          if (cur_rail == R_HIGH) hi_seg_en[seg_i] <= 1'b0;
          else                    lo_seg_en[seg_i] <= 1'b0;
          if (seg_i == SEG_LAST) begin
            seg_i <= '0;
            state <= (tgt_rail == R_OFF) ? S_SETTLE : S_ADD;
          end else begin
            seg_i <= seg_i + 1'b1;
          end
        end
        S_ADD: begin
          if (tgt_rail == R_HIGH) hi_seg_en[seg_i] <= 1'b1;
          else                    lo_seg_en[seg_i] <= 1'b1;
          if (seg_i == SEG_LAST) begin
            seg_i <= '0;
            state <= S_SETTLE;
          end else begin
            seg_i <= seg_i + 1'b1;
          end
        end
        S_SETTLE: begin
          if (set_cnt == SET_LAST) begin
            state    <= S_IDLE;
            cur_rail <= tgt_rail;
            osc_div  <= tgt_div;
          end else begin
            set_cnt <= set_cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !osc_run) div_cnt <= '0;
    else                    div_cnt <= clk_tick ? '0 : div_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_cnt  <= '0;
      idle_halt <= 1'b0;
    end else begin
      if (core_idle && fifo_empty) begin
        if (idle_cnt == WIN_LAST) idle_halt <= 1'b1;
        else                      idle_cnt  <= idle_cnt + 1'b1;
      end else begin
        idle_cnt <= '0;
      end
      if (!fifo_empty) idle_halt <= 1'b0;
    end
  end

  p_rails_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !((|hi_seg_en) && (|lo_seg_en)));

  p_one_segment_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(hi_seg_en ^ $past(hi_seg_en)) + $countones(lo_seg_en ^ $past(lo_seg_en))) <= 1);

  p_halt_on_switch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(hi_seg_en) || !$stable(lo_seg_en)) |-> !osc_run);

  p_done_full_bank_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ((&hi_seg_en) || (&lo_seg_en) || (hi_seg_en == '0 && lo_seg_en == '0)));

  p_target_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(tgt_rail));
endmodule

// File: tb/tile_dvfs_ctrl_test.sv
module tile_dvfs_ctrl_test;
  logic clk = 0, rst_n = 0;
  logic [1:0] src_sel = 0, cfg_rail = 2, sw_rail = 0;
  logic [3:0] cfg_div = 0, sw_div = 0, osc_div;
  logic sw_we = 0, core_stall = 0, core_idle = 0;
  logic [6:0] fifo_level = 0;
  logic [47:0] hi_seg_en, lo_seg_en;
  logic osc_run, clk_tick, busy;

  tile_dvfs_ctrl uut (.clk(clk), .rst_n(rst_n), .src_sel(src_sel), .cfg_rail(cfg_rail),
    .cfg_div(cfg_div), .sw_we(sw_we), .sw_rail(sw_rail), .sw_div(sw_div),
    .fifo_level(fifo_level), .core_stall(core_stall), .core_idle(core_idle),
    .hi_seg_en(hi_seg_en), .lo_seg_en(lo_seg_en), .osc_run(osc_run),
    .clk_tick(clk_tick), .osc_div(osc_div), .busy(busy));

  always #2 clk = ~clk;

  typedef struct { int rail; int dur; } exp_t;
  exp_t sb[$];
  int nvec = 0, nerr = 0, cyc = 0, busy_len = 0;
  bit mid_mode = 0, done = 0, v_excl = 0, v_step = 0, v_halt = 0, prev_busy = 0;
  logic [47:0] p_hi = '1, p_lo = '0;

  task automatic chk(string tag, int act, int exp);
    nvec++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(int rail, int dur);
    exp_t e;
    e.rail = rail; e.dur = dur;
    sb.push_back(e);
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic wait_win();
    @(negedge clk);
    while (cyc % 256 != 0) @(negedge clk);
  endtask

  task automatic count_ticks(int n, output int t);
    t = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (clk_tick) t++;
    end
  endtask

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  always @(negedge clk) if (mid_mode) core_stall = (cyc % 4 == 0);

  // monitor: scoreboard pop on each completed transition, per-cycle checks R3 R4 R5
  always @(negedge clk) begin
    if (rst_n) begin
      if ((|hi_seg_en) && (|lo_seg_en)) v_excl = 1;
      if ($countones(hi_seg_en ^ p_hi) + $countones(lo_seg_en ^ p_lo) > 1) v_step = 1;
      if ((hi_seg_en != p_hi || lo_seg_en != p_lo) && osc_run) v_halt = 1;
      if (busy && osc_run) v_halt = 1;
      if (clk_tick && !osc_run) v_halt = 1;
      if (busy) busy_len++;
      if (prev_busy && !busy) begin
        if (sb.size() == 0) chk("R6 unexpected transition", 1, 0);
        else begin
          exp_t e;
          e = sb.pop_front();
          chk("R4 busy length", busy_len, e.dur);
          chk("R4 high bank count", $countones(hi_seg_en), (e.rail == 2) ? 48 : 0);
          chk("R4 low bank count", $countones(lo_seg_en), (e.rail == 1) ? 48 : 0);
        end
        busy_len = 0;
      end
      prev_busy = busy;
      p_hi = hi_seg_en;
      p_lo = lo_seg_en;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nvec++; nerr++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    int t;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 high bank", $countones(hi_seg_en), 48);
    chk("R1 low bank", $countones(lo_seg_en), 0);
    chk("R1 busy", busy, 0);
    chk("R1 run", osc_run, 1);
    chk("R1 divider", osc_div, 0);

    cfg_div = 2;
    @(negedge clk);
    count_ticks(30, t);
    chk("R7 ticks at div 2", t, 10);
    chk("R7 no busy on divider change", busy, 0);

    cfg_rail = 1;
    push(1, 101);
    repeat (10) @(negedge clk);
    chk("R5 clock halted in transition", osc_run, 0);
    wait_idle();
    chk("R7 divider after rail change", osc_div, 2);

    cfg_rail = 2;
    push(2, 101);
    push(0, 53);
    repeat (20) @(negedge clk);
    cfg_rail = 0;
    wait_idle();
    repeat (5) @(negedge clk);
    wait_idle();
    chk("R5 run off when disconnected", osc_run, 0);
    count_ticks(20, t);
    chk("R5 no ticks when disconnected", t, 0);

    sw_rail = 1; sw_div = 1; sw_we = 1;
    @(negedge clk);
    sw_we = 0;
    repeat (5) @(negedge clk);
    chk("R2 software write ignored under static", busy, 0);
    chk("R2 still disconnected", $countones(lo_seg_en), 0);
    src_sel = 1;
    push(1, 53);
    wait_idle();
    count_ticks(20, t);
    chk("R2 software divider ticks", t, 10);

    wait_win();
    core_stall = 1; src_sel = 2;
    push(2, 101);
    repeat (266) @(negedge clk);
    wait_idle();
    chk("R8 high stall picks high divider", osc_div, 0);

    wait_win();
    core_stall = 0;
    push(1, 101);
    repeat (266) @(negedge clk);
    wait_idle();
    chk("R8 low stall picks slow divider", osc_div, 3);

    wait_win();
    fifo_level = 60;
    push(2, 101);
    repeat (266) @(negedge clk);
    wait_idle();
    chk("R8 full fifo picks high", $countones(hi_seg_en), 48);

    wait_win();
    fifo_level = 0; mid_mode = 1;
    repeat (600) @(negedge clk);
    chk("R8 mid band keeps high", $countones(hi_seg_en), 48);
    chk("R8 mid band no transition", busy, 0);
    mid_mode = 0; core_stall = 0;

    src_sel = 0; cfg_rail = 2; cfg_div = 0;
    core_idle = 1;
    repeat (200) @(negedge clk);
    chk("R9 still running before window", osc_run, 1);
    repeat (100) @(negedge clk);
    chk("R9 halted after idle window", osc_run, 0);
    fifo_level = 1;
    #1;
    chk("R9 immediate restart", osc_run, 1);
    @(negedge clk);

    chk("R3 banks never overlap", v_excl, 0);
    chk("R4 one segment per cycle", v_step, 0);
    chk("R5 clock stopped while segments move", v_halt, 0);
    chk("R6 all expected transitions seen", sb.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule